// File: doc/BRIEF.md
# Premultiplied-Alpha Restore Stage for a Four-Pipe Blender

This block sits at the input of a multi-pipe pixel blender. It accepts four ARGB pixel streams that arrive together under one valid strobe. Each pipe has one configuration bit. When that bit is set, the pipe's colour channels are treated as premultiplied by alpha, and the stage brings back straight colour by dividing each of R, G and B by alpha normalised to the range 0 to 1. The quotient is rounded to the nearest integer and saturated at full scale. When the bit is clear, the pipe's pixel goes through untouched. In both cases alpha is passed on as it arrived.

Software writes the per-pipe flags into a shadow register through a one-cycle write strobe. The shadow value takes effect only on a frame-start pulse, so a frame is never processed under two different settings. The flag that governs a pixel is the one in force on the clock edge that captures the pixel. The division is a restoring divider with one register per quotient bit. Pipes that are not restoring go through a delay line of matching depth, so all four streams leave the block aligned, a fixed number of cycles after they entered.

Top module: `upm_unpremul_stage`

## Requirements
- R1: Bit n of the configuration word (bit 0 = pipe 0, up to bit 3 = pipe 3) selects restore mode for pipe n only. Pipe n occupies bits [32n+31:32n] of the pixel buses, and inside a pipe alpha is bits [31:24], red [23:16], green [15:8] and blue [7:0].
- R2: A configuration write with `frame_start` low changes only the shadow word. Pixels captured before the next `frame_start` edge keep the previous mode.
- R3: When `cfg_wr_en` and `frame_start` are high in the same cycle, the word being written is the one applied, and it governs pixels captured from the following edge on.
- R4: In restore mode, with alpha A nonzero, each colour output equals floor((C*255 + floor(A/2)) / A), which is C*255/A rounded to nearest.
- R5: In restore mode, a colour result that would exceed 255 is output as 255.
- R6: In restore mode, a pixel whose alpha is 0 has all three colour outputs forced to 0.
- R7: Alpha is output unchanged on every pipe, and a pipe in pass mode outputs its whole pixel unchanged.
- R8: Every pixel captured on a rising edge with `in_valid` high appears on `out_pix`, with `out_valid` high, in the cycle after the ninth following edge (a latency of 10 edges counting the capture edge). No other cycle has `out_valid` high.
- R9: After reset all pipes are in pass mode and `out_valid` is low.
- R10: A mode change applied while pixels stream affects only pixels captured after the applying edge. Pixels already inside the pipeline finish under the mode they entered with.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous reset, active low |
| cfg_wr_en | input | 1 | Write strobe for the shadow mode word |
| cfg_wr_data | input | 4 | Per-pipe restore flags, bit n for pipe n |
| frame_start | input | 1 | Applies the shadow word to the active mode word |
| in_valid | input | 1 | Input pixels valid on all four pipes |
| in_pix | input | 128 | Four ARGB8888 pixels, pipe n at bits [32n+31:32n] |
| out_valid | output | 1 | Output pixels valid |
| out_pix | output | 128 | Four aligned ARGB8888 result pixels, same layout |

## Verification
A configuration write and a frame-start pulse can land in the same cycle. The same applying edge can also capture a pixel. The bench drives both overlaps: a write together with `frame_start`, and `frame_start` in the middle of an unbroken pixel stream, with the mask changing and pixels on either side of the edge. A reference model keeps its own shadow and active words and updates them in the order the requirements set. The pixel on the applying edge is judged under the old mask and the pixel after it under the new one. Each output is compared against rounded division worked out in a different form, (2*C*255 + A) / (2*A), and the cycle in which each output appears is checked against the fixed latency.

// File: rtl/upm_pkg.sv
package upm_pkg;
  // Default geometry shared by the stage and its bench.
  localparam int unsigned UPM_NPIPE_DEF = 4;
  localparam int unsigned UPM_CW_DEF    = 8;
  localparam int unsigned UPM_NCH       = 4;   // A, R, G, B per pixel
  localparam int unsigned UPM_NCOL      = 3;   // colour channels only

  typedef enum logic {
    UPM_PASS    = 1'b0,
    UPM_RESTORE = 1'b1
  } upm_mode_e;
endpackage

// File: rtl/upm_mode_ctrl.sv
module upm_mode_ctrl #(
  parameter int unsigned NPIPE = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  logic [NPIPE-1:0] wr_data,
  input  logic             frame_start,
  output logic [NPIPE-1:0] active_mask
);
  logic [NPIPE-1:0] shadow_q;
  logic [NPIPE-1:0] active_q;
  logic             apply_evt;
  logic             write_evt;

  assign apply_evt = frame_start;
  assign write_evt = wr_en;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      shadow_q <= '0;
      active_q <= '0;
    end else begin
      if (write_evt) shadow_q <= wr_data;
      if (apply_evt) active_q <= write_evt ? wr_data : shadow_q;
    end
  end

  assign active_mask = active_q;

  // R2: the active word only moves on a frame-start pulse
  a_r2_hold_between_frames: assert property (@(posedge clk) disable iff (!rst_n)
    !frame_start |=> $stable(active_mask));

  // R3: a write that coincides with frame start wins
  a_r3_write_wins: assert property (@(posedge clk) disable iff (!rst_n)
    (frame_start && wr_en) |=> (active_mask == $past(wr_data)));
endmodule

// File: rtl/upm_chan_div.sv
module upm_chan_div #(
  parameter int unsigned CW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [CW-1:0] col_i,
  input  logic [CW-1:0] alp_i,
  output logic [CW-1:0] col_o
);
  localparam int unsigned NW  = 2 * CW;
  localparam int unsigned STG = CW;
  localparam logic [CW-1:0] FULL = '1;

  // Rounded numerator: C * full-scale + A/2
  function automatic logic [NW-1:0] upm_numer(input logic [CW-1:0] c, input logic [CW-1:0] a);
    upm_numer = (NW'(c) * NW'(FULL)) + NW'(a >> 1);
  endfunction

  // Quotient would need more than CW bits
  function automatic logic upm_exceeds(input logic [NW-1:0] n, input logic [CW-1:0] a);
    upm_exceeds = (n >= (NW'(a) << CW));
  endfunction

  logic [NW-1:0] rem_q  [0:STG];
  logic [CW-1:0] den_q  [0:STG];
  logic [CW-1:0] quo_q  [0:STG];
  logic          zero_q [0:STG];
  logic          sat_q  [0:STG];
  logic [NW-1:0] trial  [1:STG];
  logic          fits   [1:STG];
  logic [NW-1:0] numer_w;

  // named events at the end of the divider, for the checks below
  logic          last_zero;
  logic          last_sat;
  logic [NW-1:0] last_rem;
  logic [CW-1:0] last_den;

  assign numer_w = upm_numer(col_i, alp_i);

  always_comb begin
    for (int i = 1; i <= STG; i++) begin
      trial[i] = NW'(den_q[i-1]) << (STG - i);
      fits[i]  = (rem_q[i-1] >= trial[i]);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i <= STG; i++) begin
        rem_q[i]  <= '0;
        den_q[i]  <= '0;
        quo_q[i]  <= '0;
        zero_q[i] <= 1'b1;
        sat_q[i]  <= 1'b0;
      end
      col_o <= '0;
    end else begin
      rem_q[0]  <= numer_w;
      den_q[0]  <= alp_i;
      quo_q[0]  <= '0;
      zero_q[0] <= (alp_i == '0);
      sat_q[0]  <= upm_exceeds(numer_w, alp_i);
      for (int i = 1; i <= STG; i++) begin
        rem_q[i]  <= fits[i] ? (rem_q[i-1] - trial[i]) : rem_q[i-1];
        den_q[i]  <= den_q[i-1];
        quo_q[i]  <= quo_q[i-1] | (fits[i] ? (CW'(1) << (STG - i)) : '0);
        zero_q[i] <= zero_q[i-1];
        sat_q[i]  <= sat_q[i-1];
      end
      col_o <= zero_q[STG] ? '0 : (sat_q[STG] ? FULL : quo_q[STG]);
    end
  end

  assign last_zero = zero_q[STG];
  assign last_sat  = sat_q[STG];
  assign last_rem  = rem_q[STG];
  assign last_den  = den_q[STG];

  // R6: zero alpha gives zero colour
  a_r6_zero_alpha: assert property (@(posedge clk) disable iff (!rst_n)
    last_zero |=> (col_o == '0));

  // R5: overflow clamps to full scale
  a_r5_no_overflow: assert property (@(posedge clk) disable iff (!rst_n)
    (last_sat && !last_zero) |=> (col_o == FULL));

  // R4: a finished in-range division leaves a remainder below the divisor
  a_r4_remainder_bound: assert property (@(posedge clk) disable iff (!rst_n)
    (!last_zero && !last_sat) |-> (last_rem < NW'(last_den)));
endmodule

// File: rtl/upm_pipe_lane.sv
module upm_pipe_lane
  import upm_pkg::*;
#(
  parameter int unsigned CW = 8
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  restore,
  input  logic [UPM_NCH*CW-1:0] pix_i,
  output logic [UPM_NCH*CW-1:0] pix_o
);
  localparam int unsigned PW  = UPM_NCH * CW;
  localparam int unsigned LAT = CW + 2;

  logic [PW-1:0] raw_q  [0:LAT-1];
  upm_mode_e     mode_q [0:LAT-1];
  logic [CW-1:0] quo_w  [0:UPM_NCOL-1];
  logic [PW-1:0] restored_w;

  for (genvar k = 0; k < UPM_NCOL; k++) begin : g_col
    upm_chan_div #(.CW(CW)) div_i (
      .clk   (clk),
      .rst_n (rst_n),
      .col_i (pix_i[k*CW +: CW]),
      .alp_i (pix_i[UPM_NCOL*CW +: CW]),
      .col_o (quo_w[k])
    );
    assign restored_w[k*CW +: CW] = quo_w[k];
  end
  assign restored_w[UPM_NCOL*CW +: CW] = raw_q[LAT-1][UPM_NCOL*CW +: CW];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < LAT; i++) begin
        raw_q[i]  <= '0;
        mode_q[i] <= UPM_PASS;
      end
    end else begin
      raw_q[0]  <= pix_i;
      mode_q[0] <= restore ? UPM_RESTORE : UPM_PASS;
      for (int i = 1; i < LAT; i++) begin
        raw_q[i]  <= raw_q[i-1];
        mode_q[i] <= mode_q[i-1];
      end
    end
  end

  assign pix_o = (mode_q[LAT-1] == UPM_RESTORE) ? restored_w : raw_q[LAT-1];
endmodule

// File: rtl/upm_unpremul_stage.sv
module upm_unpremul_stage
  import upm_pkg::*;
#(
  parameter int unsigned NPIPE = UPM_NPIPE_DEF,
  parameter int unsigned CW    = UPM_CW_DEF
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic                        cfg_wr_en,
  input  logic [NPIPE-1:0]            cfg_wr_data,
  input  logic                        frame_start,
  input  logic                        in_valid,
  input  logic [NPIPE*UPM_NCH*CW-1:0] in_pix,
  output logic                        out_valid,
  output logic [NPIPE*UPM_NCH*CW-1:0] out_pix
);
  localparam int unsigned PW  = UPM_NCH * CW;
  localparam int unsigned LAT = CW + 2;

  logic [NPIPE-1:0] active_mask;
  logic [LAT-1:0]   vld_q;

  upm_mode_ctrl #(.NPIPE(NPIPE)) ctrl_i (
    .clk         (clk),
    .rst_n       (rst_n),
    .wr_en       (cfg_wr_en),
    .wr_data     (cfg_wr_data),
    .frame_start (frame_start),
    .active_mask (active_mask)
  );

  for (genvar p = 0; p < NPIPE; p++) begin : g_pipe
    upm_pipe_lane #(.CW(CW)) lane_i (
      .clk     (clk),
      .rst_n   (rst_n),
      .restore (active_mask[p]),
      .pix_i   (in_pix[p*PW +: PW]),
      .pix_o   (out_pix[p*PW +: PW])
    );
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) vld_q <= '0;
    else        vld_q <= {vld_q[LAT-2:0], in_valid};
  end

  assign out_valid = vld_q[LAT-1];

  // R9: nothing leaves the stage in the cycle after reset is released
  a_r9_quiet_after_reset: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rst_n) |-> !out_valid);
endmodule

// File: tb/upm_unpremul_stage_tb_top.sv
module upm_unpremul_stage_tb_top;
  localparam int NP  = 4;
  localparam int CW  = 8;
  localparam int LAT = CW + 2;
  localparam int PB  = NP * 4 * CW;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          cfg_wr_en = 1'b0;
  logic [NP-1:0] cfg_wr_data = '0;
  logic          frame_start = 1'b0;
  logic          in_valid = 1'b0;
  logic [PB-1:0] in_pix = '0;
  logic          out_valid;
  logic [PB-1:0] out_pix;

  int checks = 0;
  int fails  = 0;
  int cyc    = 0;
  bit done   = 1'b0;
  bit mon_on = 1'b0;

  logic [PB-1:0] exp_q [$];
  int            due_q [$];
  string         tag_q [$];
  logic [NP-1:0] shd_m = '0;
  logic [NP-1:0] act_m = '0;
  logic [31:0]   lfsr  = 32'h1badcafe;

  upm_unpremul_stage dut_i (
    .clk(clk), .rst_n(rst_n), .cfg_wr_en(cfg_wr_en), .cfg_wr_data(cfg_wr_data),
    .frame_start(frame_start), .in_valid(in_valid), .in_pix(in_pix),
    .out_valid(out_valid), .out_pix(out_pix)
  );

  always #5 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  // Reference colour: nearest of C*255/A as (2*C*255 + A) / (2*A), clamped.
  function automatic logic [7:0] ref_col(input int c, input int a);
    int q;
    if (a == 0) return 8'd0;
    q = (2 * c * 255 + a) / (2 * a);
    return (q > 255) ? 8'd255 : q[7:0];
  endfunction

  function automatic logic [PB-1:0] ref_pix(input logic [PB-1:0] px, input logic [NP-1:0] m);
    logic [PB-1:0] r;
    r = px;
    for (int p = 0; p < NP; p++) begin
      if (m[p]) begin
        for (int k = 0; k < 3; k++)
          r[p*32 + k*8 +: 8] = ref_col(int'(px[p*32 + k*8 +: 8]), int'(px[p*32 + 24 +: 8]));
      end
    end
    return r;
  endfunction

  function automatic logic [PB-1:0] pix4(input logic [31:0] p0, input logic [31:0] p1,
                                         input logic [31:0] p2, input logic [31:0] p3);
    return {p3, p2, p1, p0};
  endfunction

  function automatic logic [31:0] xs(input logic [31:0] s);
    logic [31:0] v;
    v = s ^ (s << 13);
    v = v ^ (v >> 17);
    return v ^ (v << 5);
  endfunction

  // Driver: one cycle of stimulus, with the model updated in the same order as the edge.
  task automatic step(input logic wr, input logic [NP-1:0] wd, input logic fs,
                      input logic v, input logic [PB-1:0] px, input string tag);
    cfg_wr_en   = wr;
    cfg_wr_data = wd;
    frame_start = fs;
    in_valid    = v;
    in_pix      = px;
    if (v) begin
      exp_q.push_back(ref_pix(px, act_m));   // mode in force before the capturing edge
      due_q.push_back(cyc + LAT);            // R8: seen at the negedge after edge cyc+1+LAT-1
      tag_q.push_back(tag);
    end
    if (fs) act_m = wr ? wd : shd_m;
    if (wr) shd_m = wd;
    @(negedge clk);
  endtask

  task automatic pix(input logic [PB-1:0] px, input string tag);
    step(1'b0, '0, 1'b0, 1'b1, px, tag);
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) step(1'b0, '0, 1'b0, 1'b0, '0, "");
  endtask

  // Monitor: pops expectations as results emerge.
  always @(negedge clk) begin
    if (mon_on && !done && out_valid) begin
      checks++;
      if (exp_q.size() == 0) begin
        fails++;
        $display("FAIL R8 out_valid with nothing outstanding at cycle %0d, expected none", cyc);
      end else begin
        logic [PB-1:0] e;
        int d;
        string t;
        e = exp_q.pop_front();
        d = due_q.pop_front();
        t = tag_q.pop_front();
        if (out_pix !== e) begin
          fails++;
          $display("FAIL %s pixel got %h expected %h", t, out_pix, e);
        end
        if (cyc != d) begin
          fails++;
          $display("FAIL R8 (%s) output at cycle %0d expected %0d", t, cyc, d);
        end
      end
    end
  end

  initial begin : watchdog
    repeat (20000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL watchdog expired, got hang expected finish");
      done = 1'b1;
      $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
      $finish;
    end
  end

  initial begin : main
    logic [31:0] r;
    repeat (3) @(negedge clk);
    // R9: out_valid low while in reset
    checks++;
    if (out_valid !== 1'b0) begin fails++; $display("FAIL R9 out_valid in reset got %b expected 0", out_valid); end
    rst_n = 1'b1;
    @(negedge clk);
    mon_on = 1'b1;
    checks++;
    if (out_valid !== 1'b0) begin fails++; $display("FAIL R9 out_valid after reset got %b expected 0", out_valid); end

    // R9 / R7: reset mask is all pass
    pix(pix4(32'h7f7f7f7f, 32'h40808080, 32'h00123456, 32'h80404040), "R9 reset pass mode");
    pix(pix4(32'h01ffffff, 32'h10101010, 32'hff00ff00, 32'h20202020), "R7 pass unchanged");

    // R2: write without frame start has no effect
    step(1'b1, 4'b0101, 1'b0, 1'b1, pix4(32'h7f7f7f7f, 32'h7f7f7f7f, 32'h7f7f7f7f, 32'h7f7f7f7f), "R2 write held");
    pix(pix4(32'h80404040, 32'h80404040, 32'h80404040, 32'h80404040), "R2 shadow only");
    // apply shadow; pixel captured on this edge still uses the old mask
    step(1'b0, '0, 1'b1, 1'b1, pix4(32'h80404040, 32'h80404040, 32'h80404040, 32'h80404040), "R10 applying edge");
    // R1: only pipes 0 and 2 restore now
    pix(pix4(32'h7f7f7f7f, 32'h7f7f7f7f, 32'h80404040, 32'h80404040), "R1 bit n to pipe n");
    pix(pix4(32'h80402010, 32'h80402010, 32'hc0603010, 32'hc0603010), "R4 rounding");
    pix(pix4(32'h4080ff41, 32'h4080ff41, 32'h01ff0102, 32'h01ff0102), "R5 saturate");
    pix(pix4(32'h00557fff, 32'h00557fff, 32'h00010203, 32'h00010203), "R6 zero alpha");
    pix(pix4(32'hff123456, 32'h03010203, 32'hfeabcdef, 32'h05020304), "R4 odd alpha");

    // R3: write and frame start in the same cycle
    step(1'b1, 4'b1010, 1'b1, 1'b0, '0, "");
    pix(pix4(32'h80404040, 32'h80404040, 32'h80404040, 32'h80404040), "R3 write wins");
    pix(pix4(32'h00ffffff, 32'h00ffffff, 32'h40ff0020, 32'h40ff0020), "R6 zero alpha pipe1");
    idle(3);

    // R10: streaming with mask changes mid-stream
    for (int i = 0; i < 40; i++) begin
      lfsr = xs(lfsr);
      r = lfsr;
      if (i % 7 == 3) step(1'b1, r[3:0], 1'b1, 1'b1, {4{r}}, "R10 stream change");
      else            pix({4{r ^ 32'h5a5a5a5a}}, "R10 stream");
    end

    // R1 / R4 / R5 / R6 / R7: random traffic with occasional mask updates and gaps
    for (int i = 0; i < 400; i++) begin
      logic [PB-1:0] px;
      for (int p = 0; p < NP; p++) begin
        lfsr = xs(lfsr);
        px[p*32 +: 32] = lfsr;
        if (lfsr[2:0] == 3'd0) px[p*32 + 24 +: 8] = 8'h00;
      end
      lfsr = xs(lfsr);
      if (i % 37 == 5)      step(1'b1, lfsr[7:4], 1'b0, 1'b1, px, "R2 random write");
      else if (i % 37 == 20) step(1'b0, '0, 1'b1, 1'b1, px, "R1 random apply");
      else if (lfsr[9:8] == 2'b00) idle(1);
      else                   pix(px, "R4 random");
    end

    idle(LAT + 3);
    // R8: everything sent has come out
    checks++;
    if (exp_q.size() != 0) begin
      fails++;
      $display("FAIL R8 outstanding pixels got %0d expected 0", exp_q.size());
    end
    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end
endmodule